// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus in the SMBus/I2C style. It owns a bank of 8-bit configuration bytes whose contents drive the surrounding clock logic. A bus master reaches the bank through a fixed 7-bit device address. The first byte after the address is a command byte. That byte selects a single-byte transfer or a counted block transfer, and it also names the starting register offset.

The slave samples SCL and SDA with the system clock through a two-stage synchronizer. It recognises start and stop conditions and pulls SDA low through an output-enable to acknowledge a byte or to send a zero bit. Stretching SCL and filtering glitches are not part of this block.

Block reads are bounded by a byte-count limit held in the register bank itself. To read more bytes in one block, the master first writes a larger value into the limit register.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only device address 0x69 (address byte 0xD2 for write, 0xD3 for read). For any other address it leaves SDA released for the rest of that transaction and changes no register.
- R2: A command byte with bit 7 = 1 selects byte mode, and bits 6:0 give the offset. The data byte that follows is stored at that offset and acknowledged. A second data byte in the same transaction is not acknowledged and is not stored.
- R3: Byte read: command with bit 7 = 1, then a repeated start, then 0xD3. The slave returns the register at the offset. Any further byte the master clocks out reads as 0xFF.
- R4: A command byte with bit 7 = 0 selects block mode. In a block write, the next byte is a count N. The following N data bytes go to consecutive offsets starting at the command offset, and each one is acknowledged. Data bytes beyond N are not acknowledged and are discarded.
- R5: Block read: command with bit 7 = 0, then a repeated start, then 0xD3. The slave first returns the limit register value L, then L bytes from consecutive offsets, then 0xFF for any further byte.
- R6: The limit register sits at offset 8 and resets to 15. It can be written like any other register, and a larger value extends block reads past 15 bytes.
- R7: Offset 5 is reserved, and offsets 24 and above do not exist. Writes to them are acknowledged but discarded, and they read as 0x00.
- R8: After reset, all registers are 0x00 except offset 8, which is 15. SDA is released.
- R9: A start or stop condition in the middle of a byte aborts the transfer. The partial byte is not stored, bytes already acknowledged stay stored, and the slave accepts a new address at once.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: After a stop, a read addressed without a command byte returns the register at offset 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level seen on the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_o | output | 1 | Data value driven when enabled (always 0, open drain) |
| sda_oe | output | 1 | High to pull SDA low |
| cfg_q | output | NREG*8 | Register bank contents, offset k in bits 8k+7:8k |

## Verification
The situations hardest to reach from the pins are an abort that lands between bit edges of a data byte, and a block read that runs past the programmed limit. The bench makes the abort case with a bus-master model that clocks only part of a byte and then issues a stop, or a repeated start, before the ninth clock. It then reads neighbouring offsets back to show which bytes survived. For the limit case, the bench first drives a block read at the reset limit and clocks one byte beyond it. It then rewrites the limit register and repeats the read, so that offsets past 15 are returned.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int              NREG     = 24,
  parameter logic [6:0]      DEV_ADDR = 7'h69,
  parameter int              LIM_OFS  = 8,
  parameter logic [7:0]      LIM_RST  = 8'd15,
  parameter logic [NREG-1:0] RSVD     = 24'h000020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_q
);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_RX   = 3'd1;
  localparam logic [2:0] S_ACK  = 3'd2;
  localparam logic [2:0] S_TX   = 3'd3;
  localparam logic [2:0] S_MACK = 3'd4;

  localparam logic [1:0] K_ADDR = 2'd0;
  localparam logic [1:0] K_CMD  = 2'd1;
  localparam logic [1:0] K_CNT  = 2'd2;
  localparam logic [1:0] K_DATA = 2'd3;

  logic [2:0] scl_q, sda_q;
  logic [2:0] st;
  logic [1:0] kind;
  logic [3:0] bitc;
  logic [7:0] sh, txsh, left;
  logic [6:0] ptr;
  logic       blk, go_tx, send_cnt, mack, oe;
  logic [7:0] regs [NREG];
  logic [7:0] rd_val, nxt_tx, lim;
  logic       rx_ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  logic scl_rise, scl_fall, bus_start, bus_stop, sda_bit;
  assign sda_bit   = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign bus_start = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign bus_stop  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  assign sda_o  = 1'b0;
  assign sda_oe = oe;
  assign lim    = regs[LIM_OFS];

  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ptr == 7'(i) && !RSVD[i]) rd_val = regs[i];
  end

  assign nxt_tx = send_cnt ? lim : ((left != 8'd0) ? rd_val : 8'hFF);

  always_comb
    case (kind)
      K_ADDR:  rx_ack = (sh[7:1] == DEV_ADDR);
      K_DATA:  rx_ack = (left != 8'd0);
      default: rx_ack = 1'b1;
    endcase

  logic rx_end, wr_en, tx_load;
  assign rx_end  = scl_fall && st == S_RX && bitc == 4'd8;
  assign wr_en   = rx_end && kind == K_DATA && left != 8'd0;
  assign tx_load = scl_fall && ((st == S_ACK && go_tx) || (st == S_MACK && mack));

  always_ff @(posedge clk or negedge rst_n)
    for (int i = 0; i < NREG; i++)
      if (!rst_n)
        regs[i] <= (i == LIM_OFS) ? LIM_RST : 8'h00;
      else if (wr_en && ptr == 7'(i) && !RSVD[i])
        regs[i] <= sh;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_q[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; bitc <= 4'd0; sh <= 8'h00; txsh <= 8'h00;
      oe <= 1'b0; ptr <= 7'd0; blk <= 1'b0; left <= 8'd1;
      go_tx <= 1'b0; send_cnt <= 1'b0; mack <= 1'b0;
    end else if (bus_stop) begin
      st <= S_IDLE; oe <= 1'b0; ptr <= 7'd0; blk <= 1'b0; left <= 8'd1;
      go_tx <= 1'b0; send_cnt <= 1'b0;
    end else if (bus_start) begin
      st <= S_RX; kind <= K_ADDR; bitc <= 4'd0; oe <= 1'b0;
      go_tx <= 1'b0; send_cnt <= 1'b0;
    end else if (tx_load) begin
      st <= S_TX; txsh <= nxt_tx; oe <= ~nxt_tx[7]; bitc <= 4'd0;
      if (send_cnt) begin
        send_cnt <= 1'b0;
        left     <= lim;
      end else if (left != 8'd0) begin
        ptr  <= ptr + 7'd1;
        left <= left - 8'd1;
      end
    end else begin
      case (st)
        S_RX:
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_bit};
            bitc <= bitc + 4'd1;
          end else if (rx_end) begin
            if (rx_ack) begin
              st <= S_ACK;
              oe <= 1'b1;
              case (kind)
                K_ADDR:
                  if (sh[0]) begin
                    go_tx    <= 1'b1;
                    send_cnt <= blk;
                  end else kind <= K_CMD;
                K_CMD: begin
                  blk  <= ~sh[7];
                  ptr  <= sh[6:0];
                  left <= {7'd0, sh[7]};
                  kind <= sh[7] ? K_DATA : K_CNT;
                end
                K_CNT: begin
                  left <= sh;
                  kind <= K_DATA;
                end
                default: begin
                  ptr  <= ptr + 7'd1;
                  left <= left - 8'd1;
                end
              endcase
            end else st <= S_IDLE;
          end
        S_ACK:
          if (scl_fall) begin
            oe   <= 1'b0;
            st   <= S_RX;
            bitc <= 4'd0;
          end
        S_TX:
          if (scl_fall) begin
            bitc <= bitc + 4'd1;
            if (bitc == 4'd7) begin
              oe <= 1'b0;
              st <= S_MACK;
            end else begin
              txsh <= {txsh[6:0], 1'b0};
              oe   <= ~txsh[6];
            end
          end
        S_MACK:
          if (scl_rise) mack <= ~sda_bit;
          else if (scl_fall) st <= S_IDLE;
        default: ;
      endcase
    end

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int              NREG = 24,
  parameter logic [NREG-1:0] RSVD = 24'h000020
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [2:0]        st,
  input logic              scl_fall,
  input logic [NREG*8-1:0] cfg_q
);

  logic [7:0] rsv_or;
  always_comb begin
    rsv_or = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (RSVD[i]) rsv_or = rsv_or | cfg_q[i*8 +: 8];
  end

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_or == 8'h00);

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  a_r9_bank_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(scl_fall));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .RSVD(RSVD)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .st(st), .scl_fall(scl_fall), .cfg_q(cfg_q)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_o, sda_oe;
  logic [24*8-1:0] cfg_q;
  wire sda_i = ~(m_low | sda_oe);

  always #4 clk = ~clk;

  smb_cfg_slave u_smb_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_i),
    .sda_o(sda_o), .sda_oe(sda_oe), .cfg_q(cfg_q)
  );

  int checks = 0, errs = 0, viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] mdl [0:127];
  logic [7:0] rdbuf [0:63];

  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== oe_prev)) viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expv(input int off);
    return (off < 24 && off != 5) ? mdl[off] : 8'h00;
  endfunction

  function automatic void mwr(input int off, input logic [7:0] v);
    if (off < 24 && off != 5) mdl[off] = v;
  endfunction

  task automatic hw(); repeat (8) @(negedge clk); endtask

  task automatic bstart();
    m_low = 1'b0; hw(); scl = 1'b1; hw(); m_low = 1'b1; hw(); scl = 1'b0; hw();
  endtask

  task automatic bstop();
    m_low = 1'b1; hw(); scl = 1'b1; hw(); m_low = 1'b0; hw();
  endtask

  task automatic wbit(input logic b);
    m_low = ~b; hw(); scl = 1'b1; hw(); scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    m_low = 1'b0; hw(); scl = 1'b1;
    repeat (4) @(negedge clk);
    ack = ~sda_i;
    repeat (4) @(negedge clk);
    scl = 1'b0; hw();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    b = 8'h00;
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      hw(); scl = 1'b1;
      repeat (4) @(negedge clk);
      b = {b[6:0], sda_i};
      repeat (4) @(negedge clk);
      scl = 1'b0;
    end
    m_low = mack; hw(); scl = 1'b1; hw(); scl = 1'b0; m_low = 1'b0; hw();
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] v, output logic ok);
    logic a1, a2, a3;
    bstart(); wbyte(8'hD2, a1); wbyte({1'b1, off}, a2); wbyte(v, a3); bstop();
    ok = a1 & a2 & a3;
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] v);
    logic a;
    bstart(); wbyte(8'hD2, a); wbyte({1'b1, off}, a);
    bstart(); wbyte(8'hD3, a); rbyte(1'b0, v); bstop();
  endtask

  task automatic block_read(input logic [6:0] off, input int n, output logic [7:0] cnt);
    logic a;
    logic [7:0] t;
    bstart(); wbyte(8'hD2, a); wbyte({1'b0, off}, a);
    bstart(); wbyte(8'hD3, a); rbyte(1'b1, cnt);
    for (int i = 0; i < n; i++) begin rbyte(1'b1, t); rdbuf[i] = t; end
    rbyte(1'b0, t); rdbuf[n] = t;
    bstop();
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    report();
  end

  initial begin
    logic a, ok;
    logic [7:0] v, c;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    mdl[8] = 8'd15;
    repeat (5) @(negedge clk);
    rst_n = 1'b1; hw();

    // R8 reset state
    chk("R8 sda_oe after reset", sda_oe, 0);
    chk("R8 limit byte reset", cfg_q[8*8 +: 8], 15);
    chk("R8 offset0 reset", cfg_q[7:0], 0);
    byte_read(7'd8, v); chk("R8 limit readback", v, 15);

    // R1 foreign addresses ignored
    bstart(); wbyte(8'hA4, a); chk("R1 addr A4 nack", a, 0);
    wbyte(8'h80, a); chk("R1 silent after miss", a, 0);
    wbyte(8'h5A, a); chk("R1 data not acked", a, 0); bstop();
    bstart(); wbyte(8'hD0, a); chk("R1 addr D0 nack", a, 0); bstop();
    byte_read(7'd0, v); chk("R1 offset0 unchanged", v, 0);

    // R4 block write offset 0 count 7, eighth byte refused
    bstart(); wbyte(8'hD2, a); wbyte(8'h00, a); chk("R4 cmd ack", a, 1);
    wbyte(8'd7, a); chk("R4 count ack", a, 1);
    for (int i = 0; i < 8; i++) begin
      v = 8'h11 * 8'(i + 1);
      wbyte(v, a);
      chk($sformatf("R4 data ack %0d", i), a, (i < 7) ? 1 : 0);
      if (i < 7) mwr(i, v);
    end
    bstop();

    // R5 block read at default limit
    block_read(7'd0, 15, c);
    chk("R5 count byte", c, 15);
    for (int i = 0; i < 15; i++) chk($sformatf("R5 data %0d", i), rdbuf[i], expv(i));
    chk("R5 past limit", rdbuf[15], 8'hFF);

    // R2/R7 byte write sweep and readback
    for (int off = 0; off < 32; off++) begin
      if (off == 8) continue;
      v = 8'((off * 37 + 5) & 255);
      byte_write(7'(off), v, ok);
      chk($sformatf("R2 R7 write ack off %0d", off), ok, 1);
      mwr(off, v);
    end
    for (int off = 0; off < 32; off++) begin
      byte_read(7'(off), v);
      chk($sformatf("R2 R7 readback off %0d", off), v, expv(off));
    end
    for (int off = 0; off < 24; off++)
      chk($sformatf("R2 R7 cfg_q off %0d", off), cfg_q[off*8 +: 8], expv(off));

    // R2 second data byte in byte mode
    bstart(); wbyte(8'hD2, a); wbyte(8'h80 | 8'd20, a);
    wbyte(8'h6B, a); chk("R2 first data ack", a, 1);
    wbyte(8'hC4, a); chk("R2 second data nack", a, 0); bstop();
    mwr(20, 8'h6B);
    byte_read(7'd20, v); chk("R2 off20 stored", v, expv(20));
    byte_read(7'd21, v); chk("R2 off21 untouched", v, expv(21));

    // R3 byte read then extra byte
    bstart(); wbyte(8'hD2, a); wbyte(8'h83, a);
    bstart(); wbyte(8'hD3, a); chk("R3 read addr ack", a, 1);
    rbyte(1'b1, v); chk("R3 data", v, expv(3));
    rbyte(1'b0, v); chk("R3 extra byte", v, 8'hFF); bstop();

    // R6 larger limit
    byte_write(7'd8, 8'd20, ok); mwr(8, 8'd20);
    block_read(7'd2, 20, c);
    chk("R6 count byte", c, 20);
    for (int i = 0; i < 20; i++) chk($sformatf("R6 data off %0d", i + 2), rdbuf[i], expv(i + 2));
    chk("R6 past limit", rdbuf[20], 8'hFF);

    // R9 stop mid-byte
    bstart(); wbyte(8'hD2, a); wbyte(8'h10, a); wbyte(8'd3, a);
    wbyte(8'hA5, a); chk("R9 first byte ack", a, 1);
    for (int i = 7; i >= 4; i--) wbit(v[i]);
    bstop(); mwr(16, 8'hA5);
    byte_read(7'd16, v); chk("R9 kept byte", v, expv(16));
    byte_read(7'd17, v); chk("R9 partial dropped", v, expv(17));
    // R9 repeated start mid-byte
    bstart(); wbyte(8'hD2, a); wbyte(8'h80 | 8'd18, a);
    for (int i = 0; i < 5; i++) wbit(1'b0);
    bstart(); wbyte(8'hD2, a); chk("R9 addr after abort", a, 1);
    wbyte(8'h80 | 8'd19, a); wbyte(8'h42, a); chk("R9 new write ack", a, 1); bstop();
    mwr(19, 8'h42);
    byte_read(7'd18, v); chk("R9 off18 untouched", v, expv(18));
    byte_read(7'd19, v); chk("R9 off19 written", v, expv(19));

    // R11 read without command
    bstart(); wbyte(8'hD3, a); rbyte(1'b0, v); bstop();
    chk("R11 default offset", v, expv(0));

    chk("R10 drive changes with SCL low", viol, 0);
    report();
  end
endmodule